// File: doc/BRIEF.md
# Redundant Store Comparison Buffer

This block sits between two redundant copies of one instruction stream and the memory write port. The leading copy pushes each store (address, data, byte-enable mask) into a circular buffer as soon as it retires. The trailing copy later presents its own independently computed version of the same store. The buffer compares that version against the oldest entry that has not yet been checked. Only when address, data and byte mask all agree does the entry become verified. Verified entries then drain to memory in program order.

A disagreement in any field is treated as a transient fault. The block raises a sticky fault flag and captures the buffer slot and both copies of the store. It also stops releasing anything to memory, so a corrupted store can never reach memory. The leading copy is held off while the buffer is full, and the trailing copy is held off while it has nothing to be compared against. The depth must be a power of two and defaults to 64.

Top module: `store_check_buffer`

## Requirements
- R1: After reset, lead_ready is 1, and trail_ready, mem_valid and fault are all 0.
- R2: A leading store is accepted when lead_valid and lead_ready are both 1. lead_ready is 0 exactly while DEPTH stores are held (accepted but not yet committed), which stalls the leading copy.
- R3: Each trailing store is compared with the oldest entry that has been accepted but not yet checked. Entries are checked strictly in the order they were accepted.
- R4: A trailing store whose address, data and byte mask all equal that entry's fields verifies the entry. A verified entry may appear on the memory port from the following cycle.
- R5: trail_ready is 0 whenever no accepted entry is waiting to be checked. A trail_valid presented then is not consumed and does not change any output.
- R6: Verified entries are presented on mem_addr, mem_data and mem_be oldest first, at most one per cycle, and each leaves on a cycle with mem_valid and mem_ready both 1. While mem_ready is 0, the presented store is held unchanged.
- R7: mem_valid is 1 only when at least one verified and uncommitted entry exists. An entry that is unchecked, or that failed its check, is never presented.
- R8: A trailing store that differs from its entry in address, data or byte mask sets fault from the next cycle until reset. The same edge captures fault_idx, which is the slot of that entry, equal to the number of stores accepted before it modulo DEPTH. The same edge also captures the entry's fields on fault_exp_* and the trailing fields on fault_got_*. All of these stay unchanged afterwards.
- R9: While fault is 1, mem_valid and trail_ready are 0, even if verified entries remain. Leading stores are still accepted until the buffer is full.
- R10: Slot indices and pointers wrap modulo DEPTH, so ordering, checking and fault_idx stay correct after more than DEPTH stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| lead_valid | input | 1 | Leading copy offers a store |
| lead_ready | output | 1 | Buffer can take a leading store |
| lead_addr | input | AW | Leading store address |
| lead_data | input | DW | Leading store data |
| lead_be | input | DW/8 | Leading store byte mask |
| trail_valid | input | 1 | Trailing copy offers its store |
| trail_ready | output | 1 | Buffer will check the trailing store |
| trail_addr | input | AW | Trailing store address |
| trail_data | input | DW | Trailing store data |
| trail_be | input | DW/8 | Trailing store byte mask |
| mem_valid | output | 1 | A verified store is offered to memory |
| mem_ready | input | 1 | Memory takes the offered store |
| mem_addr | output | AW | Committed store address |
| mem_data | output | DW | Committed store data |
| mem_be | output | DW/8 | Committed store byte mask |
| fault | output | 1 | Sticky mismatch flag |
| fault_idx | output | log2(DEPTH) | Buffer slot of the failing entry |
| fault_exp_addr | output | AW | Buffered (leading) address of failing entry |
| fault_exp_data | output | DW | Buffered (leading) data of failing entry |
| fault_exp_be | output | DW/8 | Buffered (leading) byte mask of failing entry |
| fault_got_addr | output | AW | Trailing address that failed |
| fault_got_data | output | DW | Trailing data that failed |
| fault_got_be | output | DW/8 | Trailing byte mask that failed |

## Verification
The main path is driven with random, overlapping leading, trailing and memory traffic. Because memory back-pressure is random, entries wait in all three states (unchecked, verified, committed). This separates correct per-state counting from counting that only works when the buffer drains at once. It also wraps the pointers many times. A fill-only pattern with no trailing stores drives the buffer to its full limit and checks the stall at exactly DEPTH entries. Three directed mismatch cases corrupt only the data, only the address, or only the byte mask. Each case shows that every field takes part in the comparison. The cases differ in two further ways: whether a verified store is still waiting when the fault lands, and whether the slot index has already wrapped.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Which fields of a trailing store disagree with its buffered twin.
    typedef struct packed {
        logic addr_ne;
        logic data_ne;
        logic be_ne;
    } sbc_diff_t;

endpackage

// File: rtl/sbc_entry_ram.sv
module sbc_entry_ram #(
    parameter int DEPTH = 64,
    parameter int EW    = 68,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [IW-1:0] raddr_chk,
    output logic [EW-1:0] rdata_chk,
    input  logic [IW-1:0] raddr_out,
    output logic [EW-1:0] rdata_out
);

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Two combinational read ports: one for checking, one for committing.
    assign rdata_chk = mem_q[raddr_chk];
    assign rdata_out = mem_q[raddr_out];

endmodule

// File: rtl/sbc_compare.sv
module sbc_compare
    import sbc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int BW  = DW / 8
) (
    input  logic [AW-1:0] exp_addr,
    input  logic [DW-1:0] exp_data,
    input  logic [BW-1:0] exp_be,
    input  logic [AW-1:0] got_addr,
    input  logic [DW-1:0] got_data,
    input  logic [BW-1:0] got_be,
    output sbc_diff_t     diff,
    output logic          match
);

    logic [BW-1:0] lane_ne;

    // Per-byte-lane data comparison.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign lane_ne[g] = exp_data[g*8 +: 8] != got_data[g*8 +: 8];
    end

    always_comb begin
        diff.addr_ne = exp_addr != got_addr;
        diff.data_ne = |lane_ne;
        diff.be_ne   = exp_be != got_be;
        match        = !(diff.addr_ne || diff.data_ne || diff.be_ne);
    end

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead_valid,
    input  logic          trail_valid,
    input  logic          mem_ready,
    input  logic          match,
    input  logic [AW-1:0] exp_addr,
    input  logic [DW-1:0] exp_data,
    input  logic [BW-1:0] exp_be,
    input  logic [AW-1:0] got_addr,
    input  logic [DW-1:0] got_data,
    input  logic [BW-1:0] got_be,
    output logic          lead_ready,
    output logic          trail_ready,
    output logic          mem_valid,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] chk_idx,
    output logic [IW-1:0] out_idx,
    output logic          fault,
    output logic [IW-1:0] fault_idx,
    output logic [AW-1:0] fault_exp_addr,
    output logic [DW-1:0] fault_exp_data,
    output logic [BW-1:0] fault_exp_be,
    output logic [AW-1:0] fault_got_addr,
    output logic [DW-1:0] fault_got_data,
    output logic [BW-1:0] fault_got_be
);

    typedef struct packed {
        logic [PW-1:0] head;   // next entry to commit
        logic [PW-1:0] chk;    // next entry to check
        logic [PW-1:0] tail;   // next free slot
        logic          fault;
        logic [IW-1:0] fidx;
        logic [AW-1:0] fea;
        logic [DW-1:0] fed;
        logic [BW-1:0] feb;
        logic [AW-1:0] fga;
        logic [DW-1:0] fgd;
        logic [BW-1:0] fgb;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [PW-1:0] held, unchecked, verified;

    always_comb begin
        held        = st_q.tail - st_q.head;
        unchecked   = st_q.tail - st_q.chk;
        verified    = st_q.chk  - st_q.head;

        lead_ready  = held != PW'(DEPTH);
        trail_ready = (unchecked != '0) && !st_q.fault;
        mem_valid   = (verified  != '0) && !st_q.fault;

        st_d = st_q;
        if (lead_valid && lead_ready) begin
            st_d.tail = st_q.tail + 1'b1;
        end
        if (trail_valid && trail_ready) begin
            if (match) begin
                st_d.chk = st_q.chk + 1'b1;
            end else begin
                st_d.fault = 1'b1;
                st_d.fidx  = st_q.chk[IW-1:0];
                st_d.fea   = exp_addr;
                st_d.fed   = exp_data;
                st_d.feb   = exp_be;
                st_d.fga   = got_addr;
                st_d.fgd   = got_data;
                st_d.fgb   = got_be;
            end
        end
        if (mem_valid && mem_ready) begin
            st_d.head = st_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx         = st_q.tail[IW-1:0];
    assign chk_idx        = st_q.chk[IW-1:0];
    assign out_idx        = st_q.head[IW-1:0];
    assign fault          = st_q.fault;
    assign fault_idx      = st_q.fidx;
    assign fault_exp_addr = st_q.fea;
    assign fault_exp_data = st_q.fed;
    assign fault_exp_be   = st_q.feb;
    assign fault_got_addr = st_q.fga;
    assign fault_got_data = st_q.fgd;
    assign fault_got_be   = st_q.fgb;

endmodule

// File: rtl/store_check_buffer.sv
module store_check_buffer
    import sbc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int EW   = AW + DW + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead_valid,
    output logic          lead_ready,
    input  logic [AW-1:0] lead_addr,
    input  logic [DW-1:0] lead_data,
    input  logic [BW-1:0] lead_be,
    input  logic          trail_valid,
    output logic          trail_ready,
    input  logic [AW-1:0] trail_addr,
    input  logic [DW-1:0] trail_data,
    input  logic [BW-1:0] trail_be,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic [BW-1:0] mem_be,
    output logic          fault,
    output logic [IW-1:0] fault_idx,
    output logic [AW-1:0] fault_exp_addr,
    output logic [DW-1:0] fault_exp_data,
    output logic [BW-1:0] fault_exp_be,
    output logic [AW-1:0] fault_got_addr,
    output logic [DW-1:0] fault_got_data,
    output logic [BW-1:0] fault_got_be
);

    logic [IW-1:0] wr_idx, chk_idx, out_idx;
    logic [EW-1:0] chk_word, out_word;
    logic [AW-1:0] ref_addr;
    logic [DW-1:0] ref_data;
    logic [BW-1:0] ref_be;
    sbc_diff_t     diff;
    logic          match;

    sbc_entry_ram #(.DEPTH(DEPTH), .EW(EW)) u_ram (
        .clk       (clk),
        .we        (lead_valid && lead_ready),
        .waddr     (wr_idx),
        .wdata     ({lead_addr, lead_data, lead_be}),
        .raddr_chk (chk_idx),
        .rdata_chk (chk_word),
        .raddr_out (out_idx),
        .rdata_out (out_word)
    );

    assign {ref_addr, ref_data, ref_be} = chk_word;
    assign {mem_addr, mem_data, mem_be} = out_word;

    sbc_compare #(.AW(AW), .DW(DW)) u_cmp (
        .exp_addr (ref_addr),
        .exp_data (ref_data),
        .exp_be   (ref_be),
        .got_addr (trail_addr),
        .got_data (trail_data),
        .got_be   (trail_be),
        .diff     (diff),
        .match    (match)
    );

    sbc_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .lead_valid     (lead_valid),
        .trail_valid    (trail_valid),
        .mem_ready      (mem_ready),
        .match          (match),
        .exp_addr       (ref_addr),
        .exp_data       (ref_data),
        .exp_be         (ref_be),
        .got_addr       (trail_addr),
        .got_data       (trail_data),
        .got_be         (trail_be),
        .lead_ready     (lead_ready),
        .trail_ready    (trail_ready),
        .mem_valid      (mem_valid),
        .wr_idx         (wr_idx),
        .chk_idx        (chk_idx),
        .out_idx        (out_idx),
        .fault          (fault),
        .fault_idx      (fault_idx),
        .fault_exp_addr (fault_exp_addr),
        .fault_exp_data (fault_exp_data),
        .fault_exp_be   (fault_exp_be),
        .fault_got_addr (fault_got_addr),
        .fault_got_data (fault_got_data),
        .fault_got_be   (fault_got_be)
    );

endmodule

// File: rtl/store_check_buffer_chk.sv
module store_check_buffer_chk #(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lead_valid,
    input logic          lead_ready,
    input logic          trail_valid,
    input logic          trail_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [BW-1:0] mem_be,
    input logic          fault,
    input logic [IW-1:0] fault_idx,
    input logic [AW-1:0] fault_exp_addr,
    input logic [DW-1:0] fault_got_data
);

    // Handshake counters observed at the ports.
    logic [31:0] n_lead, n_trail, n_mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_lead  <= '0;
            n_trail <= '0;
            n_mem   <= '0;
        end else begin
            n_lead  <= n_lead  + 32'(lead_valid && lead_ready);
            n_trail <= n_trail + 32'(trail_valid && trail_ready);
            n_mem   <= n_mem   + 32'(mem_valid && mem_ready);
        end
    end

    AST_LEAD_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        lead_ready == ((n_lead - n_mem) < 32'(DEPTH))); // R2

    AST_TRAIL_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        trail_ready |-> (n_lead != n_trail)); // R5

    AST_COMMIT_VERIFIED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (n_trail != n_mem)); // R7

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (fault || (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)))); // R6

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R8

    AST_FAULT_INFO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(fault_idx) && $stable(fault_exp_addr)
                   && $stable(fault_got_data))); // R8

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_valid && !trail_ready)); // R9

endmodule

bind store_check_buffer store_check_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_store_check_buffer.sv
module test_store_check_buffer;

    localparam int CLK_P = 10;
    localparam int DEPTH = 64;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int BW    = DW / 8;
    localparam int IW    = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [BW-1:0] b;
    } st_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_valid = 1'b0, trail_valid = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] lead_addr = '0, trail_addr = '0;
    logic [DW-1:0] lead_data = '0, trail_data = '0;
    logic [BW-1:0] lead_be = '0, trail_be = '0;
    logic lead_ready, trail_ready, mem_valid, fault;
    logic [AW-1:0] mem_addr, fault_exp_addr, fault_got_addr;
    logic [DW-1:0] mem_data, fault_exp_data, fault_got_data;
    logic [BW-1:0] mem_be, fault_exp_be, fault_got_be;
    logic [IW-1:0] fault_idx;

    always #(CLK_P/2) clk = ~clk;

    store_check_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_check_buffer (.*);

    int checks = 0;
    int errors = 0;

    // Reference model state
    st_t sq[$];
    int  nver;
    int  ncommit;
    bit  mfault;
    int  mf_idx;
    st_t mf_exp, mf_got;

    // Stimulus for the next cycle
    bit  want_lead, want_trail, mr;
    st_t lead_st, trail_st;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic st_t rand_st();
        st_t s;
        s.a = $urandom;
        s.d = $urandom;
        s.b = BW'($urandom);
        return s;
    endfunction

    function automatic bit exp_lr(); return sq.size() < DEPTH; endfunction
    function automatic bit exp_tr(); return (nver < sq.size()) && !mfault; endfunction
    function automatic bit exp_mv(); return (nver > 0) && !mfault; endfunction

    task automatic cycle();
        bit lr, tr, mv;
        @(negedge clk);
        lr = exp_lr(); tr = exp_tr(); mv = exp_mv();
        chk(lead_ready == lr, "R2", "lead_ready", 64'(lead_ready), 64'(lr));
        chk(trail_ready == tr, "R5", "trail_ready", 64'(trail_ready), 64'(tr));
        chk(mem_valid == mv, "R7", "mem_valid", 64'(mem_valid), 64'(mv));
        chk(fault == mfault, "R8", "fault", 64'(fault), 64'(mfault));
        if (mv && mem_valid) begin
            chk(mem_addr == sq[0].a, "R6", "mem_addr", 64'(mem_addr), 64'(sq[0].a));
            chk(mem_data == sq[0].d, "R6", "mem_data", 64'(mem_data), 64'(sq[0].d));
            chk(mem_be == sq[0].b, "R6", "mem_be", 64'(mem_be), 64'(sq[0].b));
        end
        if (mfault && fault) begin
            chk(fault_idx == IW'(mf_idx), "R8", "fault_idx", 64'(fault_idx), 64'(mf_idx));
            chk({fault_exp_addr, fault_exp_data, fault_exp_be} == mf_exp, "R8",
                "fault_exp", 64'({fault_exp_addr, fault_exp_data}), 64'({mf_exp.a, mf_exp.d}));
            chk({fault_got_addr, fault_got_data, fault_got_be} == mf_got, "R8",
                "fault_got", 64'({fault_got_addr, fault_got_data}), 64'({mf_got.a, mf_got.d}));
        end
        lead_valid  = want_lead;
        {lead_addr, lead_data, lead_be} = lead_st;
        trail_valid = want_trail;
        {trail_addr, trail_data, trail_be} = trail_st;
        mem_ready   = mr;
        // Model update for the coming edge: check, accept, commit.
        if (want_trail && tr) begin
            if (trail_st == sq[nver]) begin
                nver++;
            end else begin
                mfault = 1'b1;
                mf_idx = (ncommit + nver) % DEPTH;
                mf_exp = sq[nver];
                mf_got = trail_st;
            end
        end
        if (want_lead && lr) sq.push_back(lead_st);
        if (mr && mv) begin
            void'(sq.pop_front());
            nver--;
            ncommit++;
        end
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        want_lead = 0; want_trail = 0; mr = 0;
        lead_valid = 0; trail_valid = 0; mem_ready = 0;
        sq.delete();
        nver = 0; ncommit = 0; mfault = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(lead_ready === 1'b1, "R1", "lead_ready after reset", 64'(lead_ready), 1);
        chk(trail_ready === 1'b0, "R1", "trail_ready after reset", 64'(trail_ready), 0);
        chk(mem_valid === 1'b0, "R1", "mem_valid after reset", 64'(mem_valid), 0);
        chk(fault === 1'b0, "R1", "fault after reset", 64'(fault), 0);
    endtask

    task automatic push_one();
        want_lead = 1; lead_st = rand_st(); want_trail = 0;
        cycle();
        want_lead = 0;
    endtask

    task automatic check_one();
        want_trail = 1; trail_st = sq[nver];
        cycle();
        want_trail = 0;
    endtask

    // kind 0: data bit flip, verified store still waiting (R9)
    // kind 1: address flip after slot wrap (R10)
    // kind 2: byte mask flip on first entry (R4)
    task automatic run_fault(input int kind, input int pre);
        st_t t;
        reset_dut();
        mr = (kind != 0);
        for (int i = 0; i < pre; i++) begin
            push_one();
            check_one();
        end
        push_one();
        push_one();
        t = sq[nver];
        case (kind)
            0: t.d = t.d ^ 32'h0000_0100;
            1: t.a = t.a ^ 32'h8000_0000;
            default: t.b = t.b ^ 4'b0010;
        endcase
        want_trail = 1; trail_st = t;
        cycle();
        want_trail = 0;
        @(negedge clk);
        chk(fault === 1'b1, "R8", "fault after corrupted copy", 64'(fault), 1);
        chk(fault_idx == IW'(pre % DEPTH), "R10", "fault slot after wrap",
            64'(fault_idx), 64'(pre % DEPTH));
        if (kind == 0)
            chk(mem_valid === 1'b0, "R9", "verified store withheld after fault", 64'(mem_valid), 0);
        // leading side keeps accepting, fault stays (R9, R8)
        mr = 1;
        want_lead = 1; lead_st = rand_st();
        repeat (4) cycle();
        want_lead = 0;
        repeat (2) cycle();
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        reset_dut();

        // Random overlapping traffic: R3, R4, R6, R7, R10
        for (int c = 0; c < 4000; c++) begin
            want_lead = ($urandom % 4) != 0;
            lead_st   = rand_st();
            want_trail = ($urandom % 3) != 0;
            trail_st  = (nver < sq.size()) ? sq[nver] : rand_st();
            mr = ($urandom % 4) != 0;
            cycle();
        end
        chk(ncommit > DEPTH, "R10", "pointer wrap reached", 64'(ncommit), 64'(DEPTH));

        // Fill to the limit with no trailing stores: R2, R5
        reset_dut();
        mr = 1;
        want_trail = 1;
        trail_st = rand_st();   // presented while nothing waits: R5
        cycle();
        want_trail = 0;
        for (int c = 0; c < DEPTH + 6; c++) begin
            want_lead = 1; lead_st = rand_st();
            cycle();
        end
        want_lead = 0;
        @(negedge clk);
        chk(lead_ready === 1'b0, "R2", "stall with DEPTH held", 64'(lead_ready), 0);
        chk(sq.size() == DEPTH, "R2", "stores accepted before stall", 64'(sq.size()), 64'(DEPTH));
        chk(mem_valid === 1'b0, "R7", "nothing verified yet", 64'(mem_valid), 0);
        for (int c = 0; c < DEPTH; c++) check_one();
        repeat (4) cycle();
        chk(sq.size() == 0, "R6", "buffer drained", 64'(sq.size()), 0);

        run_fault(0, 2);
        run_fault(1, 70);
        run_fault(2, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule